// File: doc/BRIEF.md
# Multi-vector FP32 round-to-integral unit

This execution unit takes an aligned group of two or four consecutive vector registers and rounds every 32-bit single-precision lane to an integral value. It picks the nearest integer, and an exact halfway value goes to the even neighbour. The rounded lanes land in a destination group of the same size. A single `start` pulse launches the whole operation. The unit then walks the group through a read port into a vector register file: one register per cycle, all of them before any write. It holds every rounded register in an internal buffer and only then streams the buffer out through a write port.

Because the writes only begin after the last read, a destination group that coincides with the source group still receives correct results. Two control bits are taken when the operation is accepted. One flushes subnormal inputs to zero. The other replaces every NaN result with the canonical quiet NaN. Two sticky flags report, for the operation as a whole, whether an invalid operation or a flushed input was seen. They are valid while `done` is high. The inexact condition is never reported.

Top module: `vgrp_round_unit`

## Requirements
- R1: A finite lane with biased exponent 127..149 rounds to the nearest integer. An exact tie goes to the even integer (1.5→2.0, 2.5→2.0, -2.5→-2.0, 8388607.5→8388608.0), including the case where the carry raises the exponent.
- R2: A lane with magnitude below 0.5, or exactly 0.5, becomes a zero carrying the input sign. A magnitude strictly between 0.5 and 1.0 becomes ±1.0 with the input sign.
- R3: A lane with biased exponent 150 or more (already integral), an infinity, or a zero passes through unchanged.
- R4: A signalling NaN (exponent 0xFF, mantissa non-zero, mantissa bit 22 clear) sets `flag_invalid` and is returned with bit 22 set. A quiet NaN passes unchanged and does not set the flag. With `dnan_en` set, every NaN result is 0x7FC00000.
- R5: A subnormal input gives a zero of its own sign. With `ftz_en` set, such an input also sets `flag_denorm`. With `ftz_en` clear, the flag stays clear.
- R6: With `grp4`=0 the source base register is `src_field`×2 and the destination base is `dst_field`×2, and two registers are used. With `grp4`=1 the bases are bits [2:0] of the field ×4, and four registers are used. Registers within a group are consecutive, and only the destination group is written.
- R7: Every source register is read before the first destination register is written. An in-place operation (same source and destination group) therefore gives the same results as a disjoint one.
- R8: From the clock edge that accepts `start`, the unit reads one register per cycle and then writes one register per cycle. `done` is high for exactly one cycle, and it is observed after 2N+1 edges, counting the accepting edge, for a group of N registers.
- R9: `start` asserted while the unit is busy is ignored. The running operation keeps its timing and its register group.
- R10: Rounding that changes a value raises no flag: `flag_invalid` and `flag_denorm` stay clear for an operation whose lanes are only finite normal values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation (accepted when idle) |
| grp4 | input | 1 | 0: two-register group, 1: four-register group |
| src_field | input | 4 | Source group field |
| dst_field | input | 4 | Destination group field |
| ftz_en | input | 1 | Flush subnormal inputs to zero |
| dnan_en | input | 1 | Replace NaN results with the canonical quiet NaN |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Register file read strobe |
| rd_idx | output | IDXW | Register file read index |
| rd_data | input | VLEN | Read data (same cycle as `rd_idx`) |
| wr_en | output | 1 | Register file write strobe |
| wr_idx | output | IDXW | Register file write index |
| wr_data | output | VLEN | Write data |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_denorm | output | 1 | Sticky flushed-input flag |

## Verification
Two events can fall in the same cycle: a new `start` can arrive while a sequence is still reading or writing, and a source group can be overwritten in the cycle right after its last read. The bench provokes the first by pulsing `start` with a different group two cycles into a run. It then judges the done latency and the exact set of registers written against an unperturbed run. It provokes the second with in-place groups holding random values, and compares every lane with a reference rounding model built on real arithmetic.

// File: rtl/vrnd_pkg.sv
package vrnd_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} vrnd_state_e;
    localparam logic [31:0] CANON_QNAN = 32'h7FC0_0000;
    localparam int          MAX_GROUP  = 4;
endpackage

// File: rtl/vrnd_lane.sv
module vrnd_lane
    import vrnd_pkg::*;
(
    input  logic [31:0] op,
    input  logic        ftz,
    input  logic        dnan,
    output logic [31:0] res,
    output logic        inv,
    output logic        den
);
    logic        sgn;
    logic [7:0]  ex;
    logic [22:0] mn;
    logic [4:0]  fsh;
    logic [24:0] sig, keep, rem, half, unit, shifted, sum;
    logic        up;

    always_comb begin
        sgn     = op[31];
        ex      = op[30:23];
        mn      = op[22:0];
        fsh     = 5'(8'd150 - ex);
        sig     = {2'b01, mn};
        unit    = 25'd1 << fsh;
        keep    = ~(unit - 25'd1);
        rem     = sig & ~keep;
        half    = 25'd1 << (fsh - 5'd1);
        shifted = sig >> fsh;
        up      = (rem > half) || ((rem == half) && shifted[0]);
        sum     = (sig & keep) + (up ? unit : 25'd0);
        res     = op;
        inv     = 1'b0;
        den     = 1'b0;
        if (ex == 8'hFF) begin
            if (mn != 23'd0) begin
                inv = ~mn[22];
                res = dnan ? CANON_QNAN : {sgn, 8'hFF, 1'b1, mn[21:0]};
            end
        end else if (ex == 8'd0) begin
            den = ftz && (mn != 23'd0);
            res = {sgn, 31'd0};
        end else if (ex >= 8'd150) begin
            res = op;
        end else if (ex < 8'd126) begin
            res = {sgn, 31'd0};
        end else if (ex == 8'd126) begin
            res = (mn == 23'd0) ? {sgn, 31'd0} : {sgn, 8'd127, 23'd0};
        end else if (sum[24]) begin
            res = {sgn, ex + 8'd1, 23'd0};
        end else begin
            res = {sgn, ex, sum[22:0]};
        end
    end
endmodule

// File: rtl/vrnd_vec.sv
module vrnd_vec #(
    parameter int VLEN = 128
) (
    input  logic [VLEN-1:0] vin,
    input  logic            ftz,
    input  logic            dnan,
    output logic [VLEN-1:0] vout,
    output logic            inv,
    output logic            den
);
    localparam int LANES = VLEN / 32;
    logic [LANES-1:0] inv_l, den_l;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vrnd_lane u_lane (
            .op  (vin[32*l +: 32]),
            .ftz (ftz),
            .dnan(dnan),
            .res (vout[32*l +: 32]),
            .inv (inv_l[l]),
            .den (den_l[l])
        );
    end

    assign inv = |inv_l;
    assign den = |den_l;
endmodule

// File: rtl/vgrp_round_unit.sv
module vgrp_round_unit
    import vrnd_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    grp4,
    input  logic [3:0]              src_field,
    input  logic [3:0]              dst_field,
    input  logic                    ftz_en,
    input  logic                    dnan_en,
    output logic                    busy,
    output logic                    done,
    output logic                    rd_en,
    output logic [$clog2(NREG)-1:0] rd_idx,
    input  logic [VLEN-1:0]         rd_data,
    output logic                    wr_en,
    output logic [$clog2(NREG)-1:0] wr_idx,
    output logic [VLEN-1:0]         wr_data,
    output logic                    flag_invalid,
    output logic                    flag_denorm
);
    localparam int IDXW = $clog2(NREG);
    localparam int CNTW = $clog2(MAX_GROUP);

    typedef struct packed {
        vrnd_state_e                    st;
        logic [CNTW-1:0]                cnt;
        logic [CNTW-1:0]                last;
        logic [IDXW-1:0]                sbase;
        logic [IDXW-1:0]                dbase;
        logic                           ftz;
        logic                           dnan;
        logic                           inv;
        logic                           den;
        logic [MAX_GROUP-1:0][VLEN-1:0] hold;
    } seq_t;

    seq_t            q, d;
    logic [VLEN-1:0] rnd_vec;
    logic            rnd_inv, rnd_den;

    vrnd_vec #(.VLEN(VLEN)) u_vec (
        .vin (rd_data),
        .ftz (q.ftz),
        .dnan(q.dnan),
        .vout(rnd_vec),
        .inv (rnd_inv),
        .den (rnd_den)
    );

    always_comb begin
        d       = q;
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        done    = 1'b0;
        rd_idx  = q.sbase + IDXW'(q.cnt);
        wr_idx  = q.dbase + IDXW'(q.cnt);
        wr_data = q.hold[q.cnt];
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_READ;
                    d.cnt   = '0;
                    d.last  = grp4 ? CNTW'(3) : CNTW'(1);
                    d.sbase = grp4 ? IDXW'({src_field[2:0], 2'b00}) : IDXW'({src_field, 1'b0});
                    d.dbase = grp4 ? IDXW'({dst_field[2:0], 2'b00}) : IDXW'({dst_field, 1'b0});
                    d.ftz   = ftz_en;
                    d.dnan  = dnan_en;
                    d.inv   = 1'b0;
                    d.den   = 1'b0;
                end
            end
            ST_READ: begin
                rd_en            = 1'b1;
                d.hold[q.cnt]    = rnd_vec;
                d.inv            = q.inv | rnd_inv;
                d.den            = q.den | rnd_den;
                if (q.cnt == q.last) begin
                    d.st  = ST_WRITE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CNTW'(1);
                end
            end
            ST_WRITE: begin
                wr_en = 1'b1;
                if (q.cnt == q.last) d.st = ST_DONE;
                else                 d.cnt = q.cnt + CNTW'(1);
            end
            default: begin
                done = 1'b1;
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy         = (q.st != ST_IDLE);
    assign flag_invalid = q.inv;
    assign flag_denorm  = q.den;
endmodule

// File: rtl/vrnd_chk.sv
module vrnd_chk #(
    parameter int IDXW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            rd_en,
    input logic            wr_en,
    input logic [IDXW-1:0] rd_idx,
    input logic [IDXW-1:0] wr_idx
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en)); // R7
    AST_NO_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rd_en); // R7
    AST_RD_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_idx == IDXW'($past(rd_idx) + 1'b1))); // R6
    AST_WR_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_idx == IDXW'($past(wr_idx) + 1'b1))); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en)); // R9
endmodule

bind vgrp_round_unit vrnd_chk #(.IDXW(IDXW)) u_vrnd_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .rd_idx(rd_idx),
    .wr_idx(wr_idx)
);

// File: tb/vgrp_round_unit_bench.sv
module vgrp_round_unit_bench;
    localparam int VLEN = 128;
    localparam int NREG = 32;
    localparam int IDXW = 5;
    localparam int LANES = VLEN / 32;

    // {input, expected}, dnan off, ftz off
    localparam logic [63:0] VEC [16] = '{
        {32'h3F00_0000, 32'h0000_0000},  // 0.5   R2
        {32'h3FC0_0000, 32'h4000_0000},  // 1.5   R1
        {32'h4020_0000, 32'h4000_0000},  // 2.5   R1
        {32'hC020_0000, 32'hC000_0000},  // -2.5  R1
        {32'h3F33_3333, 32'h3F80_0000},  // 0.7   R2
        {32'hBE99_999A, 32'h8000_0000},  // -0.3  R2
        {32'hBF00_0000, 32'h8000_0000},  // -0.5  R2
        {32'h4060_0000, 32'h4080_0000},  // 3.5   R1
        {32'h4B00_0001, 32'h4B00_0001},  // large R3
        {32'h7F80_0000, 32'h7F80_0000},  // inf   R3
        {32'h7F80_0001, 32'h7FC0_0001},  // sNaN  R4
        {32'hFFC0_0005, 32'hFFC0_0005},  // qNaN  R4
        {32'h4019_999A, 32'h4000_0000},  // 2.4   R1
        {32'h3F80_0000, 32'h3F80_0000},  // 1.0   R1
        {32'hBFD9_999A, 32'hC000_0000},  // -1.7  R1
        {32'h4AFF_FFFF, 32'h4B00_0000}   // 8388607.5 R1
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0, grp4 = 1'b0, ftz_en = 1'b0, dnan_en = 1'b0;
    logic [3:0]      src_field = '0, dst_field = '0;
    logic            busy, done, rd_en, wr_en, flag_invalid, flag_denorm;
    logic [IDXW-1:0] rd_idx, wr_idx;
    logic [VLEN-1:0] rd_data, wr_data;
    logic [VLEN-1:0] rf [NREG];
    logic [NREG-1:0] wrote;
    int              n_cmp = 0, n_bad = 0;
    int              cyc;

    always #4 clk = ~clk;

    vgrp_round_unit #(.VLEN(VLEN), .NREG(NREG)) u_vgrp_round_unit (
        .clk, .rst_n, .start, .grp4, .src_field, .dst_field, .ftz_en, .dnan_en,
        .busy, .done, .rd_en, .rd_idx, .rd_data, .wr_en, .wr_idx, .wr_data,
        .flag_invalid, .flag_denorm
    );

    assign rd_data = rf[rd_idx];
    always @(posedge clk) begin
        if (wr_en) begin
            rf[wr_idx]    <= wr_data;
            wrote[wr_idx] <= 1'b1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_rnd(input logic [31:0] x, input bit dn);
        logic [7:0]  e;
        logic [63:0] db;
        real         a, fl, df;
        e = x[30:23];
        if (e == 8'hFF) begin
            if (x[22:0] != 0) return dn ? 32'h7FC0_0000 : (x | 32'h0040_0000);
            return x;
        end
        if (e == 8'd0) return {x[31], 31'd0};
        if (e >= 8'd150) return x;
        db = {1'b0, 11'(e) + 11'd896, x[22:0], 29'd0};
        a  = $bitstoreal(db);
        fl = $floor(a);
        df = a - fl;
        if (df > 0.5 || (df == 0.5 && $floor(fl / 2.0) * 2.0 != fl)) fl = fl + 1.0;
        if (fl == 0.0) return {x[31], 31'd0};
        db = $realtobits(fl);
        return {x[31], 8'(db[62:52] - 11'd896), db[51:29]};
    endfunction

    task automatic run_op(input bit g4, input logic [3:0] sf, input logic [3:0] df,
                          input bit fz, input bit dn, input bit poke);
        @(negedge clk);
        wrote = '0;
        grp4 = g4; src_field = sf; dst_field = df; ftz_en = fz; dnan_en = dn;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 50) begin
            if (poke && cyc == 2) begin
                start = 1'b1; src_field = 4'd1; dst_field = 4'd1; grp4 = ~g4;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++) rf[r] = '0;
        wrote = '0;
        repeat (3) @(negedge clk);
        check("R8 reset busy/done", {62'd0, busy, done}, 64'd0);
        check("R8 reset rd/wr", {62'd0, rd_en, wr_en}, 64'd0);
        rst_n = 1'b1;

        // table walk: 4-group source base 8, destination base 20
        for (int i = 0; i < 16; i++) rf[8 + i / LANES][32*(i % LANES) +: 32] = VEC[i][63:32];
        run_op(1'b1, 4'd2, 4'd5, 1'b0, 1'b0, 1'b0);
        check("R8 done latency 4-group", 64'(cyc), 64'd9);
        for (int i = 0; i < 16; i++)
            check("R1/R2/R3/R4 table lane", {32'd0, rf[20 + i / LANES][32*(i % LANES) +: 32]},
                  {32'd0, VEC[i][31:0]});
        check("R4 invalid flag on sNaN", {63'd0, flag_invalid}, 64'd1);
        check("R5 denorm flag clear", {63'd0, flag_denorm}, 64'd0);
        check("R6 4-group written set", 64'(wrote), 64'(32'h00F0_0000));

        // 2-group field 7 (4-bit, base 14), destination field 15 (base 30)
        rf[14] = rf[8]; rf[15] = rf[9];
        run_op(1'b0, 4'd7, 4'd15, 1'b0, 1'b0, 1'b0);
        check("R8 done latency 2-group", 64'(cyc), 64'd5);
        check("R6 2-group written set", 64'(wrote), 64'(32'hC000_0000));
        for (int i = 0; i < 8; i++)
            check("R6 2-group lane", {32'd0, rf[30 + i / LANES][32*(i % LANES) +: 32]},
                  {32'd0, VEC[i][31:0]});

        // in-place random groups (source = destination)
        for (int it = 0; it < 3; it++) begin
            logic [31:0] src [8];
            for (int i = 0; i < 8; i++) begin
                src[i] = {1'($urandom), 8'(120 + $urandom % 36), 23'($urandom)};
                rf[4 + i / LANES][32*(i % LANES) +: 32] = src[i];
            end
            rf[6] = '1;
            run_op(1'b0, 4'd2, 4'd2, 1'b0, 1'b0, 1'b0);
            for (int i = 0; i < 8; i++)
                check("R7 in-place lane vs model", {32'd0, rf[4 + i / LANES][32*(i % LANES) +: 32]},
                      {32'd0, ref_rnd(src[i], 1'b0)});
            check("R6 neighbour untouched", 64'(rf[6][31:0]), 64'(32'hFFFF_FFFF));
            check("R10 no flag on inexact only", {62'd0, flag_invalid, flag_denorm}, 64'd0);
        end

        // flush-to-zero and default NaN
        rf[12] = {32'h3FC0_0000, 32'hFFC0_0005, 32'h8040_0000, 32'h0000_0001};
        rf[13] = {32'h7F80_0001, 32'hC1AC_0000, 32'h0000_0000, 32'h7F80_0000};
        rf[2] = rf[12]; rf[3] = rf[13];
        run_op(1'b0, 4'd6, 4'd0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++)
            check("R4/R5 ftz+dnan lane", {32'd0, rf[i / LANES][32*(i % LANES) +: 32]},
                  {32'd0, ref_rnd(rf[2 + i / LANES][32*(i % LANES) +: 32], 1'b1)});
        check("R5 denorm flag with ftz", {63'd0, flag_denorm}, 64'd1);
        check("R4 invalid with dnan", {63'd0, flag_invalid}, 64'd1);
        run_op(1'b0, 4'd1, 4'd0, 1'b0, 1'b0, 1'b0);
        check("R5 subnormal without ftz", 64'(rf[0][31:0]), 64'd0);
        check("R5 neg subnormal without ftz", 64'(rf[0][63:32]), 64'(32'h8000_0000));
        check("R5 no denorm flag without ftz", {63'd0, flag_denorm}, 64'd0);
        check("R4 qNaN kept without dnan", 64'(rf[0][95:64]), 64'(32'hFFC0_0005));
        check("R1 -21.5 ties to even", 64'(rf[1][95:64]), 64'(32'hC1B0_0000));

        // start while busy
        rf[8] = rf[20]; rf[9] = rf[21];
        run_op(1'b0, 4'd4, 4'd13, 1'b0, 1'b0, 1'b1);
        check("R9 latency with start while busy", 64'(cyc), 64'd5);
        @(negedge clk);
        check("R9 only own group written", 64'(wrote), 64'(32'h0C00_0000));
        check("R9 back to idle", {63'd0, busy}, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule